// File: doc/BRIEF.md
# Integer Execution Result Unit

This block is the purely combinational execute stage of a small 32-bit integer core. A decoder upstream hands it the two register operands, the already sign-extended immediate, the address of the current instruction and a handful of class flags. It returns one word to be written back to the destination register. It also returns a memory address that the load/store path uses.

One shared adder does add, subtract, immediate add, upper-immediate-plus-PC, the return-link increment and effective-address generation. A comparator supplies the two less-than results. A single shifter handles left, logical-right and arithmetic-right shifts. The arithmetic-right shift works on a double-width operand that has been sign-extended. The last stage is a fixed-priority output multiplexer. When the instruction is a load, it passes the returned load data instead of the computed value.

The word width, the link increment and the number of zeroed upper-immediate bits are parameters. A further parameter chooses how the signed compare is built: either from the unsigned compare plus a sign-bit check, or directly as a native signed compare.

Top module: `rvx_exec_alu`

## Requirements
- R1: The output source is chosen by fixed priority: `is_load` first, then `is_store`, then `is_jal`/`is_jalr`, then `is_lui`, then `is_auipc`, then `use_reg`, then `use_imm`.
- R2: When `funct3` is 0, `use_reg` with `alt_key`=0 gives src1+src2 and `use_reg` with `alt_key`=1 gives src1-src2. `use_imm` always gives src1+imm, whatever `alt_key` is.
- R3: When `funct3` is 3 (unsigned set-less-than), the result has bit 0 equal to (src1 < operand) taken unsigned, and every other bit is zero. The operand is src2 under `use_reg` and imm under `use_imm`.
- R4: When `funct3` is 2 (signed set-less-than), the result is 1 if src1 < operand as two's-complement numbers and 0 otherwise. The upper bits are zero.
- R5: When `funct3` is 1, the result is a left shift. When `funct3` is 5 with `alt_key`=0, the result is a logical right shift. The shift amount is only the low log2(XLEN) bits of the operand (bits [4:0] for 32 bits).
- R6: When `funct3` is 5 with `alt_key`=1, the result is an arithmetic right shift of src1 that fills with src1's sign bit. The shift amount uses the same low bits as R5.
- R7: `funct3` value 4 gives XOR, value 6 gives OR and value 7 gives AND, applied to src1 and the operand.
- R8: `is_lui` gives imm with its low 12 bits forced to zero.
- R9: `is_auipc` gives pc plus imm, where imm first has its low 12 bits forced to zero.
- R10: `is_jal` or `is_jalr` gives pc+4 as the link value, wrapping modulo 2^XLEN.
- R11: Under `is_load` or `is_store`, `mem_addr` equals src1+imm. Under `is_store`, the result is that same address.
- R12: Under `is_load`, the result is `load_data`.
- R13: When no flag is set, the result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src1_val | input | XLEN | First register operand |
| src2_val | input | XLEN | Second register operand |
| imm_val | input | XLEN | Decoded, sign-extended immediate |
| pc_val | input | XLEN | Address of the current instruction |
| load_data | input | XLEN | Data returned for a load |
| funct3 | input | 3 | Operation select within register/immediate classes |
| alt_key | input | 1 | Alternate-operation key (subtract / arithmetic shift) |
| use_reg | input | 1 | Register-register operation |
| use_imm | input | 1 | Register-immediate operation |
| is_lui | input | 1 | Load-upper-immediate |
| is_auipc | input | 1 | Upper immediate plus PC |
| is_jal | input | 1 | Direct jump with link |
| is_jalr | input | 1 | Register jump with link |
| is_load | input | 1 | Load |
| is_store | input | 1 | Store |
| wb_value | output | XLEN | Write-back value |
| mem_addr | output | XLEN | Effective memory address |

## Verification
The bench elaborates two copies of the block at XLEN=32. The first uses the default signed compare built from the unsigned compare plus a sign check. The second sets the parameter for a native signed compare. Every table vector is checked against a hand-derived expected value on both copies, so a fault that appears in only one compare variant is caught. With 32 bits, the shift-amount masking can be tested with amounts whose bit 5 is set. The PC wraparound of the link value can be tested at the top of the address space.

// File: rtl/rvx_alu_pkg.sv
package rvx_alu_pkg;

   typedef enum logic [2:0] {
      F3_ADD  = 3'd0,
      F3_SLL  = 3'd1,
      F3_SLT  = 3'd2,
      F3_SLTU = 3'd3,
      F3_XOR  = 3'd4,
      F3_SHR  = 3'd5,
      F3_OR   = 3'd6,
      F3_AND  = 3'd7
   } f3_e;

   typedef enum logic [2:0] {
      RS_ZERO,
      RS_LOAD,
      RS_SUM,
      RS_UPPER,
      RS_ARITH
   } res_src_e;

   typedef struct packed {
      logic load;
      logic store;
      logic jal;
      logic jalr;
      logic lui;
      logic auipc;
      logic reg_op;
      logic imm_op;
   } cls_t;

   function automatic res_src_e pick_source(cls_t c);
      if (c.load)                      return RS_LOAD;
      else if (c.store)                return RS_SUM;
      else if (c.jal || c.jalr)        return RS_SUM;
      else if (c.lui)                  return RS_UPPER;
      else if (c.auipc)                return RS_SUM;
      else if (c.reg_op || c.imm_op)   return RS_ARITH;
      else                             return RS_ZERO;
   endfunction

endpackage

// File: rtl/rvx_adder.sv
module rvx_adder #(
   parameter int W = 32
) (
   input  logic [W-1:0] a_in,
   input  logic [W-1:0] b_in,
   input  logic         sub_en,
   output logic [W-1:0] sum_out
);
   logic [W-1:0] b_eff;

   always_comb begin
      b_eff   = b_in ^ {W{sub_en}};
      sum_out = a_in + b_eff + W'(sub_en);
   end
endmodule

// File: rtl/rvx_compare.sv
module rvx_compare #(
   parameter int W       = 32,
   parameter bit DERIVED = 1'b1
) (
   input  logic [W-1:0] a_in,
   input  logic [W-1:0] b_in,
   output logic         lt_unsigned,
   output logic         lt_signed
);
   assign lt_unsigned = (a_in < b_in);

   generate
      if (DERIVED) begin : g_derived
         logic signs_match;
         assign signs_match = (a_in[W-1] == b_in[W-1]);
         assign lt_signed   = signs_match ? lt_unsigned : a_in[W-1];
      end else begin : g_native
         assign lt_signed = ($signed(a_in) < $signed(b_in));
      end
   endgenerate
endmodule

// File: rtl/rvx_shifter.sv
module rvx_shifter #(
   parameter int W   = 32,
   parameter int SHW = $clog2(W)
) (
   input  logic [W-1:0]   val_in,
   input  logic [SHW-1:0] amt,
   input  logic           go_right,
   input  logic           arith,
   output logic [W-1:0]   val_out
);
   logic [2*W-1:0] ext_val;
   logic           fill_bit;

   always_comb begin
      fill_bit = arith & val_in[W-1];
      ext_val  = {{W{fill_bit}}, val_in};
      if (go_right) val_out = W'(ext_val >> amt);
      else          val_out = val_in << amt;
   end
endmodule

// File: rtl/rvx_exec_alu.sv
module rvx_exec_alu
   import rvx_alu_pkg::*;
#(
   parameter int XLEN            = 32,
   parameter int INSN_BYTES      = 4,
   parameter int UPPER_ZERO_BITS = 12,
   parameter bit SLT_DERIVED     = 1'b1
) (
   input  logic [XLEN-1:0] src1_val,
   input  logic [XLEN-1:0] src2_val,
   input  logic [XLEN-1:0] imm_val,
   input  logic [XLEN-1:0] pc_val,
   input  logic [XLEN-1:0] load_data,
   input  logic [2:0]      funct3,
   input  logic            alt_key,
   input  logic            use_reg,
   input  logic            use_imm,
   input  logic            is_lui,
   input  logic            is_auipc,
   input  logic            is_jal,
   input  logic            is_jalr,
   input  logic            is_load,
   input  logic            is_store,
   output logic [XLEN-1:0] wb_value,
   output logic [XLEN-1:0] mem_addr
);
   localparam int SHW = $clog2(XLEN);
   localparam logic [XLEN-1:0] LINK_STEP  = XLEN'(INSN_BYTES);
   localparam logic [XLEN-1:0] UPPER_MASK = ~((XLEN'(1) << UPPER_ZERO_BITS) - XLEN'(1));

   generate
      if (XLEN < 8 || (XLEN & (XLEN - 1)) != 0) begin : g_bad_xlen
         $error("XLEN must be a power of two of at least 8");
      end
      if (UPPER_ZERO_BITS < 1 || UPPER_ZERO_BITS >= XLEN) begin : g_bad_upper
         $error("UPPER_ZERO_BITS must lie inside the word");
      end
      if (INSN_BYTES < 1) begin : g_bad_step
         $error("INSN_BYTES must be positive");
      end
   endgenerate

   cls_t            cls;
   res_src_e        src_sel;
   f3_e             op_f3;
   logic [XLEN-1:0] op_b;
   logic [XLEN-1:0] upper_imm;
   logic            mem_op;
   logic            link_op;
   logic [XLEN-1:0] add_a;
   logic [XLEN-1:0] add_b;
   logic            add_sub;
   logic [XLEN-1:0] add_sum;
   logic            lt_u;
   logic            lt_s;
   logic [XLEN-1:0] shift_res;
   logic [XLEN-1:0] arith_res;

   always_comb begin
      cls = '{load:   is_load,
              store:  is_store,
              jal:    is_jal,
              jalr:   is_jalr,
              lui:    is_lui,
              auipc:  is_auipc,
              reg_op: use_reg,
              imm_op: use_imm};
      src_sel   = pick_source(cls);
      op_f3     = f3_e'(funct3);
      op_b      = use_reg ? src2_val : imm_val;
      upper_imm = imm_val & UPPER_MASK;
      mem_op    = is_load | is_store;
      link_op   = is_jal | is_jalr;
   end

   // Operand steering for the single shared adder
   always_comb begin
      add_sub = 1'b0;
      if (mem_op) begin
         add_a = src1_val;
         add_b = imm_val;
      end else if (link_op) begin
         add_a = pc_val;
         add_b = LINK_STEP;
      end else if (is_auipc && !is_lui) begin
         add_a = pc_val;
         add_b = upper_imm;
      end else begin
         add_a   = src1_val;
         add_b   = op_b;
         add_sub = use_reg & alt_key & (op_f3 == F3_ADD);
      end
   end

   rvx_adder #(.W(XLEN)) u_adder (
      .a_in    (add_a),
      .b_in    (add_b),
      .sub_en  (add_sub),
      .sum_out (add_sum)
   );

   rvx_compare #(.W(XLEN), .DERIVED(SLT_DERIVED)) u_compare (
      .a_in        (src1_val),
      .b_in        (op_b),
      .lt_unsigned (lt_u),
      .lt_signed   (lt_s)
   );

   rvx_shifter #(.W(XLEN), .SHW(SHW)) u_shifter (
      .val_in   (src1_val),
      .amt      (op_b[SHW-1:0]),
      .go_right (op_f3 == F3_SHR),
      .arith    (alt_key),
      .val_out  (shift_res)
   );

   always_comb begin
      unique case (op_f3)
         F3_ADD:  arith_res = add_sum;
         F3_SLL:  arith_res = shift_res;
         F3_SLT:  arith_res = {{(XLEN-1){1'b0}}, lt_s};
         F3_SLTU: arith_res = {{(XLEN-1){1'b0}}, lt_u};
         F3_XOR:  arith_res = src1_val ^ op_b;
         F3_SHR:  arith_res = shift_res;
         F3_OR:   arith_res = src1_val | op_b;
         F3_AND:  arith_res = src1_val & op_b;
         default: arith_res = '0;
      endcase
   end

   always_comb begin
      unique case (src_sel)
         RS_LOAD:  wb_value = load_data;
         RS_SUM:   wb_value = add_sum;
         RS_UPPER: wb_value = upper_imm;
         RS_ARITH: wb_value = arith_res;
         default:  wb_value = '0;
      endcase
   end

   assign mem_addr = add_sum;

endmodule

// File: rtl/rvx_exec_alu_chk.sv
module rvx_exec_alu_chk #(
   parameter int XLEN       = 32,
   parameter int INSN_BYTES = 4
) (
   input logic [XLEN-1:0] src1_val,
   input logic [XLEN-1:0] imm_val,
   input logic [XLEN-1:0] pc_val,
   input logic [XLEN-1:0] load_data,
   input logic [2:0]      funct3,
   input logic            use_reg,
   input logic            use_imm,
   input logic            is_lui,
   input logic            is_auipc,
   input logic            is_jal,
   input logic            is_jalr,
   input logic            is_load,
   input logic            is_store,
   input logic [XLEN-1:0] wb_value,
   input logic [XLEN-1:0] mem_addr
);
   logic any_flag;
   logic above_arith;

   always_comb begin
      any_flag    = use_reg | use_imm | is_lui | is_auipc | is_jal | is_jalr | is_load | is_store;
      above_arith = is_lui | is_auipc | is_jal | is_jalr | is_load | is_store;

      // R12
      if (is_load) load_pass_chk: assert (wb_value == load_data);
      // R11
      if (is_load || is_store) addr_sum_chk: assert (mem_addr == src1_val + imm_val);
      // R10
      if ((is_jal || is_jalr) && !is_load && !is_store)
         link_value_chk: assert (wb_value == pc_val + XLEN'(INSN_BYTES));
      // R8
      if (is_lui && !is_jal && !is_jalr && !is_load && !is_store)
         upper_low_zero_chk: assert (wb_value[11:0] == 12'h000);
      // R3
      if ((use_reg || use_imm) && !above_arith && (funct3 == 3'd3 || funct3 == 3'd2))
         slt_upper_zero_chk: assert (wb_value[XLEN-1:1] == '0);
      // R13
      if (!any_flag) idle_zero_chk: assert (wb_value == '0);
   end
endmodule

bind rvx_exec_alu rvx_exec_alu_chk #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) u_chk (
   .src1_val  (src1_val),
   .imm_val   (imm_val),
   .pc_val    (pc_val),
   .load_data (load_data),
   .funct3    (funct3),
   .use_reg   (use_reg),
   .use_imm   (use_imm),
   .is_lui    (is_lui),
   .is_auipc  (is_auipc),
   .is_jal    (is_jal),
   .is_jalr   (is_jalr),
   .is_load   (is_load),
   .is_store  (is_store),
   .wb_value  (wb_value),
   .mem_addr  (mem_addr)
);

// File: tb/rvx_exec_alu_bench.sv
module rvx_exec_alu_bench;
   localparam int XLEN = 32;
   localparam int VW   = 8 + 3 + 1 + 6 * XLEN;
   localparam int NV   = 25;

   // class flag bits {load, store, jal, jalr, lui, auipc, reg, imm}
   localparam logic [7:0] C_NONE = 8'h00;
   localparam logic [7:0] C_LD   = 8'h80;
   localparam logic [7:0] C_ST   = 8'h40;
   localparam logic [7:0] C_JAL  = 8'h20;
   localparam logic [7:0] C_JALR = 8'h10;
   localparam logic [7:0] C_LUI  = 8'h08;
   localparam logic [7:0] C_AUI  = 8'h04;
   localparam logic [7:0] C_REG  = 8'h02;
   localparam logic [7:0] C_IMM  = 8'h01;

   // {flags, funct3, alt, src1, src2, imm, pc, load_data, expected}
   localparam logic [VW-1:0] VEC [NV] = '{
      {C_REG, 3'd0, 1'b0, 32'h5, 32'h7, 32'h0, 32'h0, 32'h0, 32'h0000000C},           // R2 add
      {C_REG, 3'd0, 1'b1, 32'h5, 32'h7, 32'h0, 32'h0, 32'h0, 32'hFFFFFFFE},           // R2 sub
      {C_IMM, 3'd0, 1'b1, 32'h10, 32'h0, 32'hFFFFFFFF, 32'h0, 32'h0, 32'h0000000F},   // R2 addi ignores key
      {C_REG, 3'd3, 1'b0, 32'h1, 32'hFFFFFFFF, 32'h0, 32'h0, 32'h0, 32'h1},           // R3
      {C_IMM, 3'd3, 1'b0, 32'hFFFFFFFF, 32'h0, 32'h1, 32'h0, 32'h0, 32'h0},           // R3 immediate
      {C_REG, 3'd2, 1'b0, 32'hFFFFFFFF, 32'h1, 32'h0, 32'h0, 32'h0, 32'h1},           // R4 signs differ
      {C_IMM, 3'd2, 1'b0, 32'h5, 32'h0, 32'hFFFFFFF0, 32'h0, 32'h0, 32'h0},           // R4 immediate
      {C_REG, 3'd2, 1'b0, 32'h80000000, 32'h80000001, 32'h0, 32'h0, 32'h0, 32'h1},    // R4 same sign
      {C_REG, 3'd5, 1'b1, 32'h80000000, 32'h24, 32'h0, 32'h0, 32'h0, 32'hF8000000},   // R6
      {C_IMM, 3'd5, 1'b1, 32'h7FFFFFF0, 32'h0, 32'h404, 32'h0, 32'h0, 32'h07FFFFFF},  // R6 immediate
      {C_REG, 3'd5, 1'b0, 32'h80000000, 32'h3F, 32'h0, 32'h0, 32'h0, 32'h1},          // R5 logical right
      {C_IMM, 3'd1, 1'b0, 32'h3, 32'h0, 32'h21, 32'h0, 32'h0, 32'h6},                 // R5 left, masked
      {C_REG, 3'd4, 1'b0, 32'hF0F0F0F0, 32'hFF00FF00, 32'h0, 32'h0, 32'h0, 32'h0FF00FF0}, // R7 xor
      {C_IMM, 3'd6, 1'b0, 32'h0F000000, 32'h0, 32'hF0, 32'h0, 32'h0, 32'h0F0000F0},   // R7 or
      {C_REG, 3'd7, 1'b0, 32'hF0F0F0F0, 32'hFF00FF00, 32'h0, 32'h0, 32'h0, 32'hF000F000}, // R7 and
      {C_LUI, 3'd0, 1'b0, 32'h0, 32'h0, 32'h12345ABC, 32'h0, 32'h0, 32'h12345000},    // R8
      {C_AUI, 3'd0, 1'b0, 32'h0, 32'h0, 32'h00002FFF, 32'h1000, 32'h0, 32'h3000},     // R9
      {C_JAL, 3'd0, 1'b0, 32'h0, 32'h0, 32'h0, 32'h100, 32'h0, 32'h104},              // R10
      {C_JALR, 3'd0, 1'b0, 32'h55, 32'h0, 32'h8, 32'hFFFFFFFC, 32'h0, 32'h0},         // R10 wrap
      {C_ST, 3'd0, 1'b0, 32'h1000, 32'h0, 32'hFFFFFFFC, 32'h0, 32'h0, 32'hFFC},       // R11
      {C_LD, 3'd0, 1'b0, 32'h1000, 32'h0, 32'h4, 32'h0, 32'hDEADBEEF, 32'hDEADBEEF},  // R12
      {C_NONE, 3'd0, 1'b0, 32'h1234, 32'h5678, 32'h9, 32'h40, 32'h77, 32'h0},         // R13
      {C_LD | C_REG, 3'd0, 1'b0, 32'h1, 32'h1, 32'h0, 32'h0, 32'hCAFE0000, 32'hCAFE0000}, // R1 load over reg
      {C_REG, 3'd1, 1'b0, 32'h5, 32'h20, 32'h0, 32'h0, 32'h0, 32'h5},                 // R5 amount 32 -> 0
      {C_JAL | C_REG, 3'd0, 1'b0, 32'h1, 32'h1, 32'h0, 32'h0, 32'h0, 32'h4}           // R1 link over reg
   };

   logic clk;
   logic [XLEN-1:0] src1_val, src2_val, imm_val, pc_val, load_data;
   logic [2:0] funct3;
   logic alt_key, use_reg, use_imm, is_lui, is_auipc, is_jal, is_jalr, is_load, is_store;
   logic [XLEN-1:0] wb_a, addr_a, wb_b, addr_b;

   int n_checks;
   int n_fails;

   initial clk = 1'b0;
   always #4 clk = ~clk;

   rvx_exec_alu u_rvx_exec_alu (
      .src1_val, .src2_val, .imm_val, .pc_val, .load_data, .funct3, .alt_key,
      .use_reg, .use_imm, .is_lui, .is_auipc, .is_jal, .is_jalr, .is_load, .is_store,
      .wb_value (wb_a), .mem_addr (addr_a)
   );

   rvx_exec_alu #(.SLT_DERIVED(1'b0)) u_rvx_exec_alu_native (
      .src1_val, .src2_val, .imm_val, .pc_val, .load_data, .funct3, .alt_key,
      .use_reg, .use_imm, .is_lui, .is_auipc, .is_jal, .is_jalr, .is_load, .is_store,
      .wb_value (wb_b), .mem_addr (addr_b)
   );

   task automatic check(input string req, input logic [XLEN-1:0] got, input logic [XLEN-1:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fails++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic drive(input logic [7:0] fl, input logic [2:0] f3, input logic alt,
                        input logic [XLEN-1:0] s1, input logic [XLEN-1:0] s2,
                        input logic [XLEN-1:0] im, input logic [XLEN-1:0] pc,
                        input logic [XLEN-1:0] ld);
      @(negedge clk);
      {is_load, is_store, is_jal, is_jalr, is_lui, is_auipc, use_reg, use_imm} = fl;
      funct3 = f3; alt_key = alt;
      src1_val = s1; src2_val = s2; imm_val = im; pc_val = pc; load_data = ld;
      #1;
   endtask

   task automatic finish_run;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   endtask

   initial begin
      #100000;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      n_checks = 0;
      n_fails  = 0;

      // R13: idle state with all flags low
      drive(C_NONE, 3'd0, 1'b0, '0, '0, '0, '0, '0);
      check("R13 idle", wb_a, 32'h0);

      for (int i = 0; i < NV; i++) begin
         logic [VW-1:0] v;
         v = VEC[i];
         drive(v[VW-1 -: 8], v[VW-9 -: 3], v[VW-12],
               v[5*XLEN +: XLEN], v[4*XLEN +: XLEN], v[3*XLEN +: XLEN],
               v[2*XLEN +: XLEN], v[XLEN +: XLEN]);
         check($sformatf("vector %0d derived", i), wb_a, v[XLEN-1:0]);
         check($sformatf("vector %0d native", i), wb_b, v[XLEN-1:0]);
      end

      // R11: load address and data at once
      drive(C_LD, 3'd0, 1'b0, 32'h2000, 32'h0, 32'h8, 32'h0, 32'h11112222);
      check("R11 load address", addr_a, 32'h2008);
      check("R12 load data", wb_a, 32'h11112222);

      // R11: store address with negative offset
      drive(C_ST, 3'd0, 1'b1, 32'h10, 32'h99, 32'hFFFFFFF0, 32'h0, 32'h0);
      check("R11 store address", addr_a, 32'h0);

      // R1: lui outranks auipc
      drive(C_LUI | C_AUI, 3'd0, 1'b0, 32'h0, 32'h0, 32'hABCDE123, 32'h4000, 32'h0);
      check("R1 lui over auipc", wb_a, 32'hABCDE000);

      // R1: store outranks jump link
      drive(C_ST | C_JAL, 3'd0, 1'b0, 32'h300, 32'h0, 32'h4, 32'h100, 32'h0);
      check("R1 store over link", wb_a, 32'h304);

      // R6: arithmetic shift by zero keeps value
      drive(C_REG, 3'd5, 1'b1, 32'h80000001, 32'h40, 32'h0, 32'h0, 32'h0);
      check("R6 shift zero", wb_a, 32'h80000001);

      // R4: signed compare with most-negative versus zero
      drive(C_IMM, 3'd2, 1'b0, 32'h80000000, 32'h0, 32'h0, 32'h0, 32'h0);
      check("R4 min vs zero derived", wb_a, 32'h1);
      check("R4 min vs zero native", wb_b, 32'h1);

      finish_run();
   end
endmodule